// File: doc/BRIEF.md
# Carry-Extended Register File Adder

This block is the integer add datapath of a small 32-bit load/store core. Every architectural register holds 33 bits. The extra top bit stores the carry-out of the add that last wrote the register. A multi-word add can therefore read its carry-in straight from a source register. There is no global flag register, and every operation uses exactly two register sources. The block contains a 32-entry register file with two combinational read ports and one write port, plus an adder that performs ADD, SUB, add-with-carry (ADC) and an unsigned set-less-than compare (SLTU).

Operations are issued with `op_valid`. They are never back-pressured: each issued operation writes its destination at the next rising clock edge. The same result also appears on the result port, `res_*`, for one cycle. This port has no ready signal and carries no back-pressure.

Results produced by other units, such as loads, enter through a valid/ready write-back port. That port shares the single register write path with the adder, and the adder always wins. The rules for back-pressure are:
- `wb_ready` is low in any cycle with `op_valid` high.
- A write-back is accepted only in a cycle where `wb_valid` and `wb_ready` are both high.
- A source that is refused must hold its request until it is accepted.

Register 0 is a constant zero.

Top module: `cxrf_top`

## Requirements
- R1: After reset every register reads 0 in all 33 bits and `res_valid` is 0.
- R2: ADD (op_code 2'b00) writes rs1[31:0]+rs2[31:0] to bits 31:0 of rd and the carry-out of that sum to bit 32.
- R3: SUB (op_code 2'b01) writes (rs1[31:0]-rs2[31:0]) modulo 2^32 to bits 31:0 of rd and 0 to bit 32.
- R4: SLTU (op_code 2'b11) writes 1 to rd when rs1[31:0] < rs2[31:0] as unsigned values, otherwise 0, with bit 32 cleared.
- R5: ADC (op_code 2'b10) writes rs1[31:0]+rs2[31:0]+rs2[32] to bits 31:0 of rd and the carry-out of that sum to bit 32, so adds of any word count chain through bit 32.
- R6: Bit 32 of a source has no effect on any result, except bit 32 of rs2 when the operation is ADC.
- R7: Register 0 always reads as 0 on both read ports, and writes to it from either an operation or the write-back port are discarded.
- R8: A 64-bit add done as ADD low words, then ADC high words, gives the same 64-bit result as the sequence ADD low words, SLTU of the low sum against one low operand, ADD high words, and ADD of that compare result.
- R9: A read port addressing the register being written in the same cycle returns the value held before that write.
- R10: `wb_ready` equals not `op_valid`. An accepted write-back stores all 33 bits of `wb_data` into `wb_addr`, and a refused one changes no register.
- R11: One cycle after an operation is issued, `res_valid` is 1 for one cycle, with `res_rd` and `res_data` equal to the destination and the 33-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 2 | 00 ADD, 01 SUB, 10 ADC, 11 SLTU |
| op_rs1 | input | 5 | First source register / read port A address |
| op_rs2 | input | 5 | Second source register / read port B address |
| op_rd | input | 5 | Destination register |
| rs1_data | output | 33 | Read port A contents |
| rs2_data | output | 33 | Read port B contents |
| wb_valid | input | 1 | Write-back request |
| wb_ready | output | 1 | Write-back accepted when high with wb_valid |
| wb_addr | input | 5 | Write-back destination |
| wb_data | input | 33 | Write-back value including bit 32 |
| res_valid | output | 1 | Result strobe, one cycle after issue |
| res_rd | output | 5 | Destination of the reported result |
| res_data | output | 33 | Reported 33-bit result |

## Verification
The hardest states to reach from the ports are source registers whose bit 32 disagrees with their arithmetic history. Examples are a high-word operand carrying a pending carry, or a plain operand with a stale top bit that must be ignored. The bench builds these states directly through the write-back port, loading 33-bit values with bit 32 chosen freely. It also forms chained carries with real ADD operations whose low words overflow.

The bench checks the 64-bit equivalence by running both instruction sequences on the same operands. It moves the carry into the high operand with a write-back of the value seen on a read port. It also holds `op_valid` and `wb_valid` high together to exercise the refused write-back.

// File: rtl/cxrf_pkg.sv
package cxrf_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_ADC  = 2'b10,
    OP_SLTU = 2'b11
  } op_e;
endpackage

// File: rtl/cxrf_regfile.sv
module cxrf_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RW  = DW + 1,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [RW-1:0] ra_data,
  output logic [RW-1:0] rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata
);
  logic [NREG-1:0][RW-1:0] rows;

  for (genvar g = 0; g < NREG; g++) begin : g_row
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_store
      logic [RW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         q <= '0;
        else if (we && waddr == AW'(g))     q <= wdata;
      end
      assign rows[g] = q;
    end
  end

  // reads see the stored value; a same-cycle write lands only at the edge
  assign ra_data = rows[ra_addr];
  assign rb_data = rows[rb_addr];

  // R7: register 0 reads as zero on both ports
  a_r7_zero_reg_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == '0) |-> (ra_data == '0 && (rb_addr != '0 || rb_data == '0)));
endmodule

// File: rtl/cxrf_adder.sv
module cxrf_adder
  import cxrf_pkg::*;
#(
  parameter int DW  = 32,
  localparam int RW = DW + 1
) (
  input  op_e           op,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  output logic [RW-1:0] result
);
  logic [DW-1:0] a_val, b_val;
  logic          cin;
  logic [DW:0]   sum;
  logic [DW:0]   diff;

  assign a_val = src_a[DW-1:0];
  assign b_val = src_b[DW-1:0];
  assign cin   = (op == OP_ADC) ? src_b[DW] : 1'b0;
  assign sum   = {1'b0, a_val} + {1'b0, b_val} + {{DW{1'b0}}, cin};
  // borrow-style subtract: diff[DW] is 1 when no borrow occurred
  assign diff  = {1'b0, a_val} + {1'b0, ~b_val} + {{DW{1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC: result = sum;
      OP_SUB:         result = {1'b0, diff[DW-1:0]};
      OP_SLTU:        result = {{DW{1'b0}}, ~diff[DW]};
      default:        result = '0;
    endcase
  end
endmodule

// File: rtl/cxrf_wport.sv
module cxrf_wport #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RW  = DW + 1,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          op_fire,
  input  logic [AW-1:0] op_rd,
  input  logic [RW-1:0] op_res,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [AW-1:0] wb_addr,
  input  logic [RW-1:0] wb_data,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [RW-1:0] wdata
);
  logic wb_take;

  assign wb_ready = ~op_fire;
  assign wb_take  = wb_valid & wb_ready;
  assign we       = op_fire | wb_take;
  assign waddr    = op_fire ? op_rd  : wb_addr;
  assign wdata    = op_fire ? op_res : wb_data;
endmodule

// File: rtl/cxrf_top.sv
module cxrf_top
  import cxrf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RW  = DW + 1,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_rs1,
  input  logic [AW-1:0] op_rs2,
  input  logic [AW-1:0] op_rd,
  output logic [RW-1:0] rs1_data,
  output logic [RW-1:0] rs2_data,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [AW-1:0] wb_addr,
  input  logic [RW-1:0] wb_data,
  output logic          res_valid,
  output logic [AW-1:0] res_rd,
  output logic [RW-1:0] res_data
);
  op_e           op;
  logic [RW-1:0] alu_res;
  logic          we;
  logic [AW-1:0] waddr;
  logic [RW-1:0] wdata;

  assign op = op_e'(op_code);

  cxrf_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(op_rs1), .rb_addr(op_rs2),
    .ra_data(rs1_data), .rb_data(rs2_data),
    .we(we), .waddr(waddr), .wdata(wdata)
  );

  cxrf_adder #(.DW(DW)) u_add (
    .op(op), .src_a(rs1_data), .src_b(rs2_data), .result(alu_res)
  );

  cxrf_wport #(.DW(DW), .NREG(NREG)) u_wp (
    .op_fire(op_valid), .op_rd(op_rd), .op_res(alu_res),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data),
    .we(we), .waddr(waddr), .wdata(wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_rd    <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_rd   <= op_rd;
        res_data <= alu_res;
      end
    end
  end

  // R11: every issued operation reports exactly one cycle later
  a_r11_result_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (res_valid && res_rd == $past(op_rd)));

  // R3 / R4: subtract and compare never leave a carry in bit 32
  a_r3_sub_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_SUB || op == OP_SLTU)) |=> (res_data[DW] == 1'b0));

  // R4: the compare result is 0 or 1
  a_r4_sltu_bool: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_SLTU) |=> (res_data[DW-1:1] == '0));

  // R10: write-back is refused whenever an operation is issued
  a_r10_wb_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !wb_ready);

  // R7: a destination of zero never becomes readable as non-zero
  a_r7_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_rd == '0) |=> (res_rd != '0 || op_rs1 != '0 || rs1_data == '0));
endmodule

// File: tb/test_cxrf_top.sv
module test_cxrf_top;
  localparam int DW = 32;
  localparam int RW = DW + 1;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'b00;
  logic [AW-1:0] op_rs1 = '0, op_rs2 = '0, op_rd = '0;
  logic [RW-1:0] rs1_data, rs2_data;
  logic          wb_valid = 1'b0;
  logic          wb_ready;
  logic [AW-1:0] wb_addr = '0;
  logic [RW-1:0] wb_data = '0;
  logic          res_valid;
  logic [AW-1:0] res_rd;
  logic [RW-1:0] res_data;

  int total = 0;
  int bad = 0;
  logic [RW-1:0] model [32];
  logic [AW+RW-1:0] sbq [$];
  logic monitor_on = 1'b0;

  always #10 clk = ~clk;

  cxrf_top i_cxrf_top (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_rs1(op_rs1), .op_rs2(op_rs2), .op_rd(op_rd),
    .rs1_data(rs1_data), .rs2_data(rs2_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] expect_of(logic [1:0] c, logic [RW-1:0] a, logic [RW-1:0] b);
    logic [DW:0] s;
    case (c)
      2'b00: s = {1'b0, a[DW-1:0]} + {1'b0, b[DW-1:0]};
      2'b10: s = {1'b0, a[DW-1:0]} + {1'b0, b[DW-1:0]} + {32'd0, b[DW]};
      2'b01: s = {1'b0, a[DW-1:0] - b[DW-1:0]};
      default: s = (a[DW-1:0] < b[DW-1:0]) ? 33'd1 : 33'd0;
    endcase
    return s;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(logic [1:0] c, logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] d);
    logic [RW-1:0] e;
    op_valid = 1'b1; op_code = c; op_rs1 = a; op_rs2 = b; op_rd = d;
    e = expect_of(c, model[a], model[b]);
    sbq.push_back({d, e});
    @(posedge clk);
    if (d != 0) model[d] = e;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_wb(logic [AW-1:0] ad, logic [RW-1:0] dat);
    wb_valid = 1'b1; wb_addr = ad; wb_data = dat;
    @(posedge clk);
    if (ad != 0) model[ad] = dat;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic chk_reg(string req, logic [AW-1:0] ad, logic [RW-1:0] exp);
    op_rs1 = ad; op_rs2 = ad;
    #1;
    check(req, 64'(rs1_data), 64'(exp));
    check(req, 64'(rs2_data), 64'(exp));
  endtask

  // scoreboard monitor (R11)
  always @(negedge clk) begin
    if (monitor_on && res_valid) begin
      if (sbq.size() == 0) check("R11 unexpected result", 64'(res_rd), 64'hFFFF);
      else begin
        logic [AW+RW-1:0] it;
        it = sbq.pop_front();
        check("R11 res_rd", 64'(res_rd), 64'(it[AW+RW-1:RW]));
        check("R11 res_data", 64'(res_data), 64'(it[RW-1:0]));
      end
    end
  end

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] lo_seq, hi_seq, lo_adc, hi_adc;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    monitor_on = 1'b1;

    // R1: reset state
    check("R1 res_valid", 64'(res_valid), 64'd0);
    chk_reg("R1 reg5", 5'd5, '0);
    chk_reg("R1 reg31", 5'd31, '0);

    // R10: loads through write-back, full 33 bits
    do_wb(5'd1, 33'h0_FFFF_FFFF);
    do_wb(5'd2, 33'h0_0000_0001);
    do_wb(5'd3, 33'h1_0000_0010);
    do_wb(5'd9, 33'h1_8000_0000);
    chk_reg("R10 stored", 5'd3, 33'h1_0000_0010);
    chk_reg("R10 stored", 5'd9, 33'h1_8000_0000);

    // R2: add with and without carry-out
    do_op(2'b00, 5'd1, 5'd2, 5'd4);
    chk_reg("R2 add carry", 5'd4, 33'h1_0000_0000);
    do_op(2'b00, 5'd9, 5'd9, 5'd10);
    chk_reg("R2 add wrap", 5'd10, 33'h1_0000_0000);

    // R6: top bits of sources ignored by ADD
    do_op(2'b00, 5'd3, 5'd2, 5'd11);
    chk_reg("R6 add ignores top", 5'd11, 33'h0_0000_0011);

    // R3: subtract, including wrap-around
    do_op(2'b01, 5'd2, 5'd1, 5'd12);
    chk_reg("R3 sub wrap", 5'd12, 33'h0_0000_0002);
    do_op(2'b01, 5'd3, 5'd2, 5'd13);
    chk_reg("R3 sub", 5'd13, 33'h0_0000_000F);

    // R4: unsigned compare, both outcomes and equal
    do_op(2'b11, 5'd2, 5'd1, 5'd14);
    chk_reg("R4 sltu true", 5'd14, 33'h0_0000_0001);
    do_op(2'b11, 5'd1, 5'd2, 5'd14);
    chk_reg("R4 sltu false", 5'd14, 33'h0_0000_0000);
    do_op(2'b11, 5'd9, 5'd9, 5'd15);
    chk_reg("R4 sltu equal", 5'd15, 33'h0_0000_0000);

    // R5: add-with-carry consumes rs2 bit 32 and produces a carry
    do_op(2'b10, 5'd2, 5'd3, 5'd16);
    chk_reg("R5 adc cin", 5'd16, 33'h0_0000_0012);
    do_op(2'b10, 5'd1, 5'd4, 5'd17);
    chk_reg("R5 adc cout", 5'd17, 33'h1_0000_0000);
    // R6: rs1 bit 32 ignored by ADC
    do_op(2'b10, 5'd3, 5'd2, 5'd18);
    chk_reg("R6 adc ignores rs1 top", 5'd18, 33'h0_0000_0011);

    // R7: register zero
    do_wb(5'd0, 33'h1_DEAD_BEEF);
    chk_reg("R7 wb to zero", 5'd0, '0);
    do_op(2'b00, 5'd1, 5'd1, 5'd0);
    chk_reg("R7 op to zero", 5'd0, '0);
    do_op(2'b00, 5'd0, 5'd2, 5'd19);
    chk_reg("R7 zero operand", 5'd19, 33'h0_0000_0001);

    // R9: read during write returns the old value
    op_valid = 1'b1; op_code = 2'b00; op_rs1 = 5'd2; op_rs2 = 5'd2; op_rd = 5'd2;
    sbq.push_back({5'd2, 33'h0_0000_0002});
    #2;
    check("R9 old value", 64'(rs1_data), 64'h1);
    @(posedge clk);
    model[2] = 33'h0_0000_0002;
    @(negedge clk);
    op_valid = 1'b0;
    chk_reg("R9 new value", 5'd2, 33'h0_0000_0002);

    // R10: refused write-back while an operation issues
    wb_valid = 1'b1; wb_addr = 5'd20; wb_data = 33'h0_1234_5678;
    op_valid = 1'b1; op_code = 2'b01; op_rs1 = 5'd2; op_rs2 = 5'd2; op_rd = 5'd21;
    sbq.push_back({5'd21, 33'h0});
    #1;
    check("R10 wb_ready low", 64'(wb_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; wb_valid = 1'b0;
    #1;
    check("R10 wb_ready high", 64'(wb_ready), 64'd1);
    chk_reg("R10 refused no write", 5'd20, '0);

    // R8: 64-bit add: A=0x00000001_FFFFFFF0  B=0x00000002_00000020
    do_wb(5'd22, 33'h0_FFFF_FFF0); // a lo
    do_wb(5'd23, 33'h0_0000_0001); // a hi
    do_wb(5'd24, 33'h0_0000_0020); // b lo
    do_wb(5'd25, 33'h0_0000_0002); // b hi
    do_op(2'b00, 5'd22, 5'd24, 5'd26); // lo sum
    do_op(2'b11, 5'd26, 5'd22, 5'd27); // carry via compare
    do_op(2'b00, 5'd23, 5'd25, 5'd28); // hi sum
    do_op(2'b00, 5'd27, 5'd28, 5'd29); // hi + carry
    op_rs1 = 5'd26; #1; lo_seq = rs1_data;
    op_rs1 = 5'd29; #1; hi_seq = rs1_data;
    @(negedge clk);
    // carry path: move lo sum bit 32 into b hi, then ADC
    do_wb(5'd30, {lo_seq[DW], model[25][DW-1:0]});
    do_op(2'b10, 5'd23, 5'd30, 5'd31);
    lo_adc = lo_seq;
    op_rs1 = 5'd31; #1; hi_adc = rs1_data;
    check("R8 low word", 64'(lo_adc[DW-1:0]), 64'h0000_0010);
    check("R8 high word equal", 64'(hi_adc[DW-1:0]), 64'(hi_seq[DW-1:0]));
    check("R8 high word value", 64'(hi_adc[DW-1:0]), 64'h0000_0004);
    @(negedge clk);

    repeat (2) @(negedge clk);
    check("R11 queue drained", 64'(sbq.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule